// File: doc/BRIEF.md
# Serial EEPROM word reader

This block drives a three-wire serial configuration EEPROM (chip select, serial clock, serial data towards the memory, serial data from the memory) to read 16-bit words. The host gives a word address and a one-cycle start strobe. The block sends a 9-bit read frame made of a fixed 3-bit read opcode and a 6-bit word address. It then clocks in sixteen data bits, drops chip select and gives one more clock pulse. The word is returned with a single-cycle done pulse. The high and low times of the serial clock are parameters counted in system clock cycles. The defaults give about 3 µs high and 2 µs low at 50 MHz.

A mode input selects a three-word fetch that builds a 48-bit station address. In this mode the block reads the given address and the two addresses after it, back to back. It places the first word in the least significant 16 bits and the last word in the most significant 16 bits. Within each word, the high byte lands in the byte that comes earlier in transmit order.

Top module: `eerd_station_reader`

## Requirements
- R1: The read frame is {3'b110, word address[5:0]}, sent most significant bit first on `ee_di`, one bit per serial clock pulse. Each bit is driven one cycle before `ee_sk` rises and is held until the pulse's low time ends.
- R2: Every serial clock pulse is 1 setup cycle with `ee_sk` low, then exactly T_HI cycles high, then exactly T_LO cycles low. `ee_cs` stays high through the 9 frame pulses and the 16 data pulses.
- R3: After the frame, `ee_di` is low and 16 pulses read the word most significant bit first. Each bit is taken in the last high cycle of its pulse.
- R4: After the 25th pulse, `ee_cs` falls while `ee_sk` is low, and one more pulse is issued with `ee_cs` low. After that, all three output lines rest low.
- R5: `ee_do` passes through a two-flop synchroniser before sampling. A memory that changes `ee_do` at the rising serial clock edge is read correctly when T_HI is at least 3.
- R6: `busy` rises in the cycle after a start is accepted. It stays high until the cycle in which `done` pulses for one cycle, and it is low in that cycle. A single read shows `done` 26*(1+T_HI+T_LO)+2 cycles after the accepting edge.
- R7: A start seen while `busy` is high is ignored. It has no effect on the lines, on `busy`/`done` or on the results.
- R8: With `rd_multi`=0, `rd_word` takes the word at `rd_addr` in the done cycle, and `station_addr` keeps its value.
- R9: With `rd_multi`=1, the words at `rd_addr`, `rd_addr`+1 and `rd_addr`+2 (modulo 64) are read in that order, with one idle cycle between them. `station_addr` becomes {w2, w1, w0} and `rd_word` becomes w2. `station_addr` changes only in a done cycle.
- R10: During and directly after reset, all lines, `busy`, `done`, `rd_word` and `station_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | Start strobe, accepted only when idle |
| rd_multi | input | 1 | 0: one word; 1: three-word station address fetch |
| rd_addr | input | ADDR_W | Word address (first word in three-word mode) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_word | output | DATA_W | Last word read |
| station_addr | output | WORDS*DATA_W | Assembled station address |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data towards the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The bench targets frame bit order, including the address wrapping past 63 in three-word mode. A shifter that was reversed or off by one would send a wrong opcode to the responder model, which would then return a wrong word. Exact high and low pulse widths, and the chip select drop before the trailing pulse, are compared every cycle. A design that sampled too early in the high phase would read the stale bit through the synchroniser. A start held high across a done cycle, and a start issued mid-transfer, are also exercised. A design that restarted while busy, or lost the back-to-back request, would break the waveform, the done timing or the stored station address.

// File: rtl/eerd_pkg.sv
package eerd_pkg;
  // read opcode occupying the top three bits of the outgoing frame
  localparam logic [2:0] RD_OPCODE = 3'b110;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SET,
    PH_HI,
    PH_LO
  } eerd_phase_e;
endpackage

// File: rtl/eerd_sync.sv
module eerd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eerd_word_engine.sv
module eerd_word_engine
  import eerd_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int T_HI        = 150,
  parameter int T_LO        = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i
);
  localparam int CMD_W     = ADDR_W + 3;
  localparam int SLOTS     = CMD_W + DATA_W + 1;
  localparam int LAST_SLOT = SLOTS - 1;
  localparam int SLOT_W    = $clog2(SLOTS + 1);
  localparam int MAX_T     = (T_HI > T_LO) ? T_HI : T_LO;
  localparam int CNT_W     = $clog2(MAX_T + 1);

  eerd_phase_e       phase_q, phase_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [CMD_W-1:0]  frame_q, frame_n;
  logic [DATA_W-1:0] shift_q;
  logic              done_n;
  logic              active_n, cs_n, sk_n, di_n;
  logic              do_sync;
  logic              sample_now;
  logic              cs_q, sk_q, di_q, done_q;

  eerd_sync #(.STAGES(SYNC_STAGES)) u_do_sync (
    .clk (clk),
    .rst (rst),
    .d_i (ee_do_i),
    .q_o (do_sync)
  );

  // phase sequencer: SET (1 cycle) -> HI (T_HI) -> LO (T_LO) per slot
  always_comb begin
    phase_n = phase_q;
    slot_n  = slot_q;
    cnt_n   = cnt_q;
    frame_n = frame_q;
    done_n  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_n = PH_SET;
          slot_n  = '0;
          frame_n = {RD_OPCODE, addr_i};
        end
      end
      PH_SET: begin
        phase_n = PH_HI;
        cnt_n   = CNT_W'(T_HI - 1);
      end
      PH_HI: begin
        if (cnt_q == '0) begin
          phase_n = PH_LO;
          cnt_n   = CNT_W'(T_LO - 1);
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      PH_LO: begin
        if (cnt_q == '0) begin
          if (slot_q == SLOT_W'(LAST_SLOT)) begin
            phase_n = PH_IDLE;
            done_n  = 1'b1;
          end else begin
            phase_n = PH_SET;
            slot_n  = slot_q + 1'b1;
            frame_n = {frame_q[CMD_W-2:0], 1'b0};
          end
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
    endcase
  end

  // line values decoded from the next state so that the pins are registered
  assign active_n = (phase_n != PH_IDLE);
  assign cs_n     = active_n && (slot_n != SLOT_W'(LAST_SLOT));
  assign sk_n     = (phase_n == PH_HI);
  assign di_n     = active_n && (slot_n < SLOT_W'(CMD_W)) && frame_n[CMD_W-1];

  // data bit taken on the last high cycle of each read pulse
  assign sample_now = (phase_q == PH_HI) && (cnt_q == '0) &&
                      (slot_q >= SLOT_W'(CMD_W)) &&
                      (slot_q < SLOT_W'(CMD_W + DATA_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      slot_q  <= '0;
      cnt_q   <= '0;
      frame_q <= '0;
      shift_q <= '0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      di_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      slot_q  <= slot_n;
      cnt_q   <= cnt_n;
      frame_q <= frame_n;
      cs_q    <= cs_n;
      sk_q    <= sk_n;
      di_q    <= di_n;
      done_q  <= done_n;
      if (sample_now) shift_q <= {shift_q[DATA_W-2:0], do_sync};
    end
  end

  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = done_q;
  assign word_o  = shift_q;
  assign ee_cs_o = cs_q;
  assign ee_sk_o = sk_q;
  assign ee_di_o = di_q;

  // high-time run length kept for the pulse width property
  logic [CNT_W:0] hi_run_q;
  always_ff @(posedge clk) begin
    if (rst)       hi_run_q <= '0;
    else if (sk_q) hi_run_q <= hi_run_q + 1'b1;
    else           hi_run_q <= '0;
  end

  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!ee_cs_o && !ee_sk_o && !ee_di_o)); // R4
  AST_SK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(ee_sk_o) |-> (hi_run_q == (CNT_W+1)'(T_HI))); // R2
  AST_DI_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o)); // R1
  AST_CS_DROP_SK_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(ee_cs_o) |-> !ee_sk_o); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6
endmodule

// File: rtl/eerd_station_reader.sv
module eerd_station_reader #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int WORDS       = 3,
  parameter int T_HI        = 150,
  parameter int T_LO        = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_start,
  input  logic                    rd_multi,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    busy,
  output logic                    done,
  output logic [DATA_W-1:0]       rd_word,
  output logic [WORDS*DATA_W-1:0] station_addr,
  output logic                    ee_cs,
  output logic                    ee_sk,
  output logic                    ee_di,
  input  logic                    ee_do
);
  localparam int SA_W   = WORDS * DATA_W;
  localparam int LEFT_W = $clog2(WORDS + 1);

  logic              busy_q, done_q, multi_q;
  logic [LEFT_W-1:0] left_q;
  logic [ADDR_W-1:0] next_addr_q;
  logic [SA_W-1:0]   acc_q, sa_q;
  logic [DATA_W-1:0] word_q;

  logic              eng_start, eng_busy, eng_done;
  logic [ADDR_W-1:0] eng_addr;
  logic [DATA_W-1:0] eng_word;
  logic [SA_W-1:0]   acc_next;

  // a new start is only passed on while idle; chained words follow a done
  assign eng_start = busy_q ? (eng_done && (left_q != '0)) : rd_start;
  assign eng_addr  = busy_q ? next_addr_q : rd_addr;
  assign acc_next  = {eng_word, acc_q[SA_W-1:DATA_W]};

  eerd_word_engine #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .T_HI        (T_HI),
    .T_LO        (T_LO),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_engine (
    .clk     (clk),
    .rst     (rst),
    .start_i (eng_start),
    .addr_i  (eng_addr),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .word_o  (eng_word),
    .ee_cs_o (ee_cs),
    .ee_sk_o (ee_sk),
    .ee_di_o (ee_di),
    .ee_do_i (ee_do)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      multi_q     <= 1'b0;
      left_q      <= '0;
      next_addr_q <= '0;
      acc_q       <= '0;
      sa_q        <= '0;
      word_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (rd_start) begin
          busy_q      <= 1'b1;
          multi_q     <= rd_multi;
          left_q      <= rd_multi ? LEFT_W'(WORDS - 1) : '0;
          next_addr_q <= rd_addr + 1'b1;
        end
      end else if (eng_done) begin
        acc_q <= acc_next;
        if (left_q != '0) begin
          left_q      <= left_q - 1'b1;
          next_addr_q <= next_addr_q + 1'b1;
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          word_q <= eng_word;
          if (multi_q) sa_q <= acc_next;
        end
      end
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign rd_word      = word_q;
  assign station_addr = sa_q;

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> !eng_start); // R7
  AST_ENGINE_IDLE_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !eng_busy); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R6
  AST_ADDR_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(station_addr) |-> done); // R9
endmodule

// File: tb/eerd_station_reader_tb_top.sv
module eerd_station_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TH = 4;
  localparam int TL = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_start = 1'b0;
  logic        rd_multi = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic        busy, done;
  logic [15:0] rd_word;
  logic [47:0] station_addr;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eerd_station_reader #(
    .ADDR_W(6), .DATA_W(16), .WORDS(3), .T_HI(TH), .T_LO(TL), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .rd_start(rd_start), .rd_multi(rd_multi),
    .rd_addr(rd_addr), .busy(busy), .done(done), .rd_word(rd_word),
    .station_addr(station_addr), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ee_word(input int a);
    return (16'(a) * 16'h3B1D) ^ 16'hC35A;
  endfunction

  // responder: captures 9 frame bits on rising clock, then drives 16 data bits
  int          m_edges = 0;
  logic [8:0]  m_cmd = '0;
  logic [15:0] m_data = '0;
  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      m_edges = 0;
      ee_do   = 1'b0;
    end else begin
      m_edges++;
      if (m_edges <= 9) m_cmd = {m_cmd[7:0], ee_di};
      if (m_edges == 9) begin
        chk(m_cmd[8:6] == 3'b110, "R1", "read opcode", 64'(m_cmd[8:6]), 64'h6);
        m_data = ee_word(int'(m_cmd[5:0]));
      end
      if (m_edges >= 10 && m_edges <= 25) ee_do = m_data[25 - m_edges];
    end
  end

  // reference model: per-cycle expected {cs, sk, di, busy, done}
  logic [4:0]  exp_q[$];
  logic [15:0] pend_word = '0, cur_word = '0;
  logic [47:0] pend_sa = '0, cur_sa = '0;
  bit          pend_multi = 1'b0;

  function automatic void push_word(input int a);
    logic [8:0] fr;
    fr = {3'b110, 6'(a)};
    for (int s = 0; s < 26; s++) begin
      logic c, d;
      c = (s < 25);
      d = (s < 9) ? fr[8 - s] : 1'b0;
      exp_q.push_back({c, 1'b0, d, 1'b1, 1'b0});
      for (int h = 0; h < TH; h++) exp_q.push_back({c, 1'b1, d, 1'b1, 1'b0});
      for (int l = 0; l < TL; l++) exp_q.push_back({c, 1'b0, d, 1'b1, 1'b0});
    end
    exp_q.push_back(5'b00010);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_q.delete();
    end else if (rd_start && exp_q.size() == 0) begin
      int a;
      a = int'(rd_addr);
      pend_multi = rd_multi;
      if (rd_multi) begin
        for (int k = 0; k < 3; k++) push_word((a + k) % 64);
        pend_word = ee_word((a + 2) % 64);
        pend_sa   = {ee_word((a + 2) % 64), ee_word((a + 1) % 64), ee_word(a)};
      end else begin
        push_word(a);
        pend_word = ee_word(a);
      end
      exp_q.push_back(5'b00001);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      logic [4:0] e;
      if (exp_q.size() != 0) e = exp_q.pop_front();
      else                   e = 5'b0;
      chk(ee_cs == e[4], "R2/R4", "ee_cs", 64'(ee_cs), 64'(e[4]));
      chk(ee_sk == e[3], "R2",    "ee_sk", 64'(ee_sk), 64'(e[3]));
      chk(ee_di == e[2], "R1",    "ee_di", 64'(ee_di), 64'(e[2]));
      chk(busy  == e[1], "R6",    "busy",  64'(busy),  64'(e[1]));
      chk(done  == e[0], "R6",    "done",  64'(done),  64'(e[0]));
      if (e[0]) begin
        cur_word = pend_word;
        if (pend_multi) cur_sa = pend_sa;
      end
      // R3 R5 R8: returned word; R9: assembled address
      chk(rd_word == cur_word, "R8", "rd_word", 64'(rd_word), 64'(cur_word));
      chk(station_addr == cur_sa, "R9", "station_addr", 64'(station_addr), 64'(cur_sa));
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic do_read(input int a, input bit multi);
    @(negedge clk);
    rd_start = 1'b1; rd_multi = multi; rd_addr = 6'(a);
    @(negedge clk);
    rd_start = 1'b0;
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!ee_cs && !ee_sk && !ee_di, "R10", "lines in reset", {ee_cs, ee_sk, ee_di}, 0);
    chk(!busy && !done, "R10", "busy/done in reset", {busy, done}, 0);
    chk(rd_word == 0 && station_addr == 0, "R10", "results in reset", 64'(rd_word), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    do_read(0, 1'b0);     // R8 lowest address
    do_read(63, 1'b0);    // R8 highest address
    do_read(42, 1'b0);    // R3 alternating frame bits
    do_read(16, 1'b1);    // R9 three-word fetch
    do_read(62, 1'b1);    // R9 address wraps 62, 63, 0
    do_read(5, 1'b0);     // R8: station_addr must keep previous value

    // R7: start mid-transfer with other address and mode is ignored
    @(negedge clk);
    rd_start = 1'b1; rd_multi = 1'b0; rd_addr = 6'd9;
    @(negedge clk);
    rd_start = 1'b0;
    repeat (60) @(negedge clk);
    rd_start = 1'b1; rd_multi = 1'b1; rd_addr = 6'd33;
    @(negedge clk);
    rd_start = 1'b0;
    wait_done();

    // R6: start held across done is taken right after the done cycle
    @(negedge clk);
    rd_start = 1'b1; rd_multi = 1'b0; rd_addr = 6'd7;
    wait_done();
    rd_addr = 6'd8;
    @(negedge clk);
    rd_start = 1'b0;
    wait_done();

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule